// File: doc/BRIEF.md
# Watchdog configuration register serial slave

This block is a two-wire serial bus slave that exposes one 8-bit configuration register for a watchdog. The register holds a two-bit timeout selection and two write-enable latches. The bus clock and data lines are sampled by the system clock. The data line is driven open-drain through an output-enable that pulls it low. A write-protect input can lock the timeout selection.

A master selects the register with a slave byte. The upper nibble of that byte must be 1011, bit 1 carries the high address bit and bit 0 is the read/write flag. On a write, a word-address byte for the low eight address bits follows, then exactly one data byte. Every write takes effect on the stop condition. Before the timeout selection can change, the two latches must be set in two earlier writes. A successful selection change raises a one-cycle commit pulse. A busy flag then follows for a fixed number of cycles, and during that time the slave ignores its address. A read returns the register in one byte, after which the slave goes idle on its own.

Top module: `wdt_cfg_i2c_slave`

## Requirements
- R1: After reset, wd_sel is 00, wel and rwel are 0, sda_oe is 0, commit is 0 and busy is 0.
- R2: The slave acknowledges a slave byte only when bits 7:4 are 1011 and bit 1 is 1. Bit 0 is 1 for a read and 0 for a write. Any other slave byte gets no acknowledge and no further response.
- R3: In a write, the slave acknowledges the word-address byte only if it is FFh. Otherwise it stops responding, and the stop that follows changes nothing.
- R4: A data byte whose bits 2:1 are 00 clears both wel and rwel. A data byte whose bits 2:1 are 01 sets wel when rwel is 0, so writing 02h sets wel.
- R5: A data byte whose bits 2:1 are 11 (for example 06h) sets rwel only when wel is already 1. Otherwise it has no effect.
- R6: A data byte whose bits 2:1 are 01, sent while rwel is 1 and wp_i is low, loads wd_sel from data bits 6:5 at the stop. It also pulses commit for exactly one cycle and clears rwel, and wel stays 1.
- R7: With wp_i high, the write of R6 leaves wd_sel unchanged, gives no commit pulse, and still clears rwel.
- R8: Only the first data byte of a write is acknowledged. Later bytes get no acknowledge and do not affect the result.
- R9: A write changes nothing until its stop. A repeated start before the stop discards the pending byte.
- R10: A read sends {0, wd_sel[1], wd_sel[0], 0, 0, rwel, wel, 0}, most significant bit first. After that byte the slave is idle and does not drive the line, even without a stop.
- R11: busy is high for BUSY_CYCLES cycles starting with the commit pulse. While busy is high, even a valid slave byte gets no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| wp_i | input | 1 | Write protect for the timeout selection |
| wd_sel | output | 2 | Watchdog timeout selection |
| wel | output | 1 | First write-enable latch |
| rwel | output | 1 | Second write-enable latch |
| commit | output | 1 | One-cycle pulse that starts a nonvolatile update |
| busy | output | 1 | Nonvolatile update in progress |

## Verification
The assertions assume that the bus lines change only well apart from each other: data never moves in the same sampled cycle as a clock edge, and each bus phase lasts several system clocks. They also assume that wp_i is steady around a stop. The stimulus moves the data line only a quarter bit-period after the clock has gone low, keeps every bus phase five clocks long, and changes write protect only between transactions. Under those conditions a start and a stop are never confused with data bits.

// File: rtl/wdt_cfg_pkg.sv
package wdt_cfg_pkg;
  localparam logic [3:0] SLAVE_PREAMBLE = 4'b1011;
  localparam logic [7:0] REG_ADDR_LOW = 8'hFF;
  localparam logic [1:0] CODE_CLEAR = 2'b00;
  localparam logic [1:0] CODE_ARM = 2'b01;
  localparam logic [1:0] CODE_UNLOCK = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADR,
    S_DATA,
    S_EXTRA,
    S_RD
  } bus_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
  import wdt_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_hi,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_rise,
  input  logic       sda_fall,
  input  logic       sda_hi,
  input  logic       busy,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       wr_valid,
  output logic [7:0] wr_byte
);
  bus_state_t st, nxt;
  logic [3:0] bitcnt;
  logic [7:0] sh;
  logic       in_ack;
  logic       pend_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      bitcnt   <= '0;
      sh       <= '0;
      in_ack   <= 1'b0;
      pend_v   <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (scl_hi && sda_fall) begin
        // start or repeated start: any pending byte is dropped
        st     <= S_DEV;
        bitcnt <= '0;
        in_ack <= 1'b0;
        pend_v <= 1'b0;
        sda_oe <= 1'b0;
      end else if (scl_hi && sda_rise) begin
        wr_valid <= pend_v;
        pend_v   <= 1'b0;
        st       <= S_IDLE;
        in_ack   <= 1'b0;
        sda_oe   <= 1'b0;
      end else if (st != S_IDLE) begin
        if (scl_rise && !in_ack && bitcnt != 4'd8) begin
          if (st != S_RD) sh <= {sh[6:0], sda_hi};
          bitcnt <= bitcnt + 4'd1;
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bitcnt <= '0;
            st     <= nxt;
            if (nxt == S_RD) begin
              sda_oe <= ~rd_byte[7];
              sh     <= {rd_byte[6:0], 1'b0};
            end else begin
              sda_oe <= 1'b0;
            end
          end else if (st == S_RD) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              in_ack <= 1'b1;
              nxt    <= S_IDLE;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
            end
          end else if (bitcnt == 4'd8) begin
            in_ack <= 1'b1;
            case (st)
              S_DEV: begin
                if (sh[7:4] == SLAVE_PREAMBLE && sh[1] && !busy) begin
                  sda_oe <= 1'b1;
                  nxt    <= sh[0] ? S_RD : S_WADR;
                end else begin
                  nxt    <= S_IDLE;
                end
              end
              S_WADR: begin
                sda_oe <= (sh == REG_ADDR_LOW);
                nxt    <= (sh == REG_ADDR_LOW) ? S_DATA : S_IDLE;
              end
              S_DATA: begin
                sda_oe  <= 1'b1;
                wr_byte <= sh;
                pend_v  <= 1'b1;
                nxt     <= S_EXTRA;
              end
              default: nxt <= S_EXTRA;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/wdt_cfg_regs.sv
module wdt_cfg_regs
  import wdt_cfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_byte,
  input  logic       wp_i,
  output logic [1:0] wd_sel,
  output logic       wel,
  output logic       rwel,
  output logic       commit,
  output logic       busy,
  output logic [7:0] rd_byte
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] busy_cnt;
  logic [1:0]    code;
  logic          unused_bits;

  assign code        = wr_byte[2:1];
  assign unused_bits = ^{wr_byte[7], wr_byte[4:3], wr_byte[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_sel   <= 2'b00;
      wel      <= 1'b0;
      rwel     <= 1'b0;
      commit   <= 1'b0;
      busy_cnt <= '0;
    end else begin
      commit <= 1'b0;
      if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
      if (wr_valid) begin
        case (code)
          CODE_CLEAR: begin
            wel  <= 1'b0;
            rwel <= 1'b0;
          end
          CODE_ARM: begin
            if (rwel) begin
              rwel <= 1'b0;
              if (!wp_i) begin
                wd_sel   <= wr_byte[6:5];
                commit   <= 1'b1;
                busy_cnt <= CW'(BUSY_CYCLES);
              end
            end else begin
              wel <= 1'b1;
            end
          end
          CODE_UNLOCK: if (wel) rwel <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign busy    = (busy_cnt != '0);
  assign rd_byte = {1'b0, wd_sel, 2'b00, rwel, wel, 1'b0};
endmodule

// File: rtl/wdt_cfg_i2c_slave.sv
module wdt_cfg_i2c_slave #(
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       wp_i,
  output logic [1:0] wd_sel,
  output logic       wel,
  output logic       rwel,
  output logic       commit,
  output logic       busy
);
  logic scl_hi, scl_rise, scl_fall;
  logic sda_hi, sda_rise, sda_fall;
  logic wr_valid;
  logic [7:0] wr_byte, rd_byte;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst(rst), .din(scl_i),
    .lvl(scl_hi), .rise(scl_rise), .fall(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst(rst), .din(sda_i),
    .lvl(sda_hi), .rise(sda_rise), .fall(sda_fall)
  );

  i2c_byte_fsm u_fsm (
    .clk(clk), .rst(rst),
    .scl_hi(scl_hi), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall), .sda_hi(sda_hi),
    .busy(busy), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  wdt_cfg_regs #(.BUSY_CYCLES(BUSY_CYCLES)) u_regs (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .wp_i(wp_i),
    .wd_sel(wd_sel), .wel(wel), .rwel(rwel),
    .commit(commit), .busy(busy), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/wdt_cfg_i2c_checker.sv
module wdt_cfg_i2c_checker (
  input logic       clk,
  input logic       rst,
  input logic       wp_i,
  input logic [1:0] wd_sel,
  input logic       wel,
  input logic       rwel,
  input logic       commit,
  input logic       busy
);
  // R6: the selection moves only together with a commit pulse
  p_wd_moves_with_commit_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(wd_sel) |-> commit);

  // R6: a commit consumes the second latch
  p_commit_clears_rwel_r6: assert property (@(posedge clk) disable iff (rst)
    commit |-> !rwel);

  // R7: no commit when write protect was high at the stop
  p_commit_needs_wp_low_r7: assert property (@(posedge clk) disable iff (rst)
    commit |-> !$past(wp_i));

  // R5: the second latch only rises while the first one is held
  p_rwel_needs_wel_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(rwel) |-> wel);

  // R11: busy starts with the commit and is still high one cycle later
  p_commit_busy_r11: assert property (@(posedge clk) disable iff (rst)
    commit |-> busy);

  p_busy_holds_r11: assert property (@(posedge clk) disable iff (rst)
    commit |=> busy && !commit);
endmodule

bind wdt_cfg_i2c_slave wdt_cfg_i2c_checker u_chk (
  .clk(clk), .rst(rst), .wp_i(wp_i), .wd_sel(wd_sel),
  .wel(wel), .rwel(rwel), .commit(commit), .busy(busy)
);

// File: tb/wdt_cfg_i2c_slave_bench.sv
module wdt_cfg_i2c_slave_bench;
  localparam int BUSY = 400;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe, wel, rwel, commit, busy;
  logic [1:0] wd_sel;
  logic line;
  int n_chk = 0;
  int n_fail = 0;
  int commit_cyc = 0;

  assign line = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  wdt_cfg_i2c_slave #(.BUSY_CYCLES(BUSY)) u_wdt_cfg_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
    .wp_i(wp), .wd_sel(wd_sel), .wel(wel), .rwel(rwel),
    .commit(commit), .busy(busy)
  );

  always @(negedge clk) if (commit) commit_cyc++;

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung (actual running, expected done)");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic i2c_bit(input logic b, output logic s);
    sda_m = b; wq(); scl = 1'b1; wq(); s = line; wq(); scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) i2c_bit(d[i], s);
    i2c_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      i2c_bit(1'b1, s);
      d[i] = s;
    end
    i2c_bit(1'b1, s);
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] adr, input logic [7:0] dat,
                        output logic a0, output logic a1, output logic a2);
    i2c_start();
    wbyte(dev, a0);
    wbyte(adr, a1);
    wbyte(dat, a2);
    i2c_stop();
    repeat (10) @(negedge clk);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // {data, wp, wd_sel, wel, rwel, commit}
  localparam logic [13:0] VEC [12] = '{
    {8'h02, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0},
    {8'h06, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0},
    {8'h42, 1'b0, 2'b10, 1'b1, 1'b0, 1'b1},
    {8'h06, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0},
    {8'h22, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0},
    {8'h06, 1'b0, 2'b10, 1'b1, 1'b1, 1'b0},
    {8'h62, 1'b0, 2'b11, 1'b1, 1'b0, 1'b1},
    {8'h00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0},
    {8'h06, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0},
    {8'h02, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0},
    {8'h22, 1'b0, 2'b11, 1'b1, 1'b0, 1'b0},
    {8'h00, 1'b0, 2'b11, 1'b0, 1'b0, 1'b0}
  };

  initial begin
    logic a0, a1, a2;
    logic [7:0] rd;
    int c0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1", {wd_sel, wel, rwel, sda_oe, commit, busy}, 7'b0);

    for (int v = 0; v < 12; v++) begin
      wp = VEC[v][5];
      c0 = commit_cyc;
      wr_txn(8'hB2, 8'hFF, VEC[v][13:6], a0, a1, a2);
      chk("R4 R5 R6 R7 acks", {a0, a1, a2}, 3'b111);
      chk("R4 R5 R6 R7 state", {wd_sel, wel, rwel}, VEC[v][4:1]);
      chk("R6 R7 commit", commit_cyc - c0, {31'd0, VEC[v][0]});
      wait_idle();
      wp = 1'b0;
    end

    // R2 wrong preamble and low high-address bit
    i2c_start(); wbyte(8'hA2, a0); i2c_stop();
    chk("R2 preamble", a0, 1'b0);
    i2c_start(); wbyte(8'hB0, a0); i2c_stop();
    chk("R2 high addr bit", a0, 1'b0);

    // R3 wrong word address
    wr_txn(8'hB2, 8'hFF, 8'h02, a0, a1, a2);
    wr_txn(8'hB2, 8'hFF, 8'h06, a0, a1, a2);
    wr_txn(8'hB2, 8'hFE, 8'h42, a0, a1, a2);
    chk("R3 acks", {a0, a1, a2}, 3'b100);
    chk("R3 state", {wd_sel, wel, rwel}, 4'b1111);

    // R8 second data byte refused
    c0 = commit_cyc;
    i2c_start(); wbyte(8'hB2, a0); wbyte(8'hFF, a1); wbyte(8'h42, a2);
    wbyte(8'h22, a0);
    i2c_stop();
    repeat (10) @(negedge clk);
    chk("R8 extra nack", a0, 1'b0);
    chk("R8 state", {wd_sel, wel, rwel}, 4'b1010);
    chk("R6 pulse width", commit_cyc - c0, 1);
    wait_idle();

    // R9 no effect before stop, repeated start discards
    wr_txn(8'hB2, 8'hFF, 8'h06, a0, a1, a2);
    i2c_start(); wbyte(8'hB2, a0); wbyte(8'hFF, a1); wbyte(8'h00, a2);
    repeat (20) @(negedge clk);
    chk("R9 before stop", {wel, rwel}, 2'b11);
    i2c_start(); i2c_stop();
    repeat (10) @(negedge clk);
    chk("R9 repeated start", {wel, rwel}, 2'b11);

    // R10 read, then idle without a stop
    i2c_start(); wbyte(8'hB3, a0); rbyte(rd);
    chk("R10 read ack", a0, 1'b1);
    chk("R10 read data", rd, 8'h46);
    rbyte(rd);
    chk("R10 idle after byte", rd, 8'hFF);
    i2c_stop();

    // R11 busy refuses the address
    wr_txn(8'hB2, 8'hFF, 8'h62, a0, a1, a2);
    chk("R11 busy set", busy, 1'b1);
    i2c_start(); wbyte(8'hB2, a0); i2c_stop();
    chk("R11 nack while busy", a0, 1'b0);
    chk("R6 value", wd_sel, 2'b11);
    wait_idle();
    chk("R11 busy cleared", busy, 1'b0);
    i2c_start(); wbyte(8'hB2, a0); i2c_stop();
    chk("R11 ack after busy", a0, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule